// File: doc/BRIEF.md
# Serial Avionics Word Transmitter with Queue

This block is the transmit half of a two-wire avionics serial link. A host with a 16-bit bus builds each 32-bit word in two writes. The low half is written on one strobe. The high half is written on a second strobe, and that second write places the assembled word into an eight-entry first-in-first-out queue.

A framer takes words from the head of the queue one at a time. It shifts each word out least significant bit first, appends an odd-parity bit, and drives the result as return-to-zero pulses on a digital high/low line pair. After every word it holds both lines at null for a fixed gap before it may start the next word.

A level-sensitive enable input lets the host stop transmission while it refills the queue. A status output tells the host when the queue holds nothing. A mode word, loaded on its own strobe, selects one of two bit rates and one of two word lengths.

Top module: `a429_word_tx`

## Requirements
- R1: While `rst_n` is low, and after it is released, `q_empty` is 1, both line outputs are 0, the queue holds no word, and the mode is fast rate with 32-bit words.
- R2: A falling edge on `cfg_wr_n` loads the mode from `host_data`. Bit 0 = 1 selects the slow rate, where a half bit cell lasts `HALF_FAST*SLOW_MULT` clocks; bit 0 = 0 selects the fast rate, where it lasts `HALF_FAST` clocks. Bit 1 = 1 selects 25-bit words; bit 1 = 0 selects 32-bit words. A word that has already started keeps the mode it started with.
- R3: A falling edge on `ld_lo_n` captures `host_data` as word bits 15:0. A falling edge on `ld_hi_n` supplies bits 31:16 and enqueues the complete word. The low-half write alone enqueues nothing.
- R4: The queue holds up to 8 words and sends them in the order they were written. A high-half write while the queue holds 8 words is dropped.
- R5: `q_empty` is 1 exactly when the queue holds no word. It falls on the clock edge that samples the high-half strobe, and a word leaves the queue on the edge where its transmission starts.
- R6: A word starts only while `tx_en` is high and the queue holds a word. While `tx_en` is low, no new word starts and both lines stay 0.
- R7: If `tx_en` falls during a word, that word and its trailing gap complete normally.
- R8: Each bit cell lasts two half cells. In the first half, a 1 drives `line_hi`=1, `line_lo`=0, and a 0 drives `line_hi`=0, `line_lo`=1. In the second half both lines are 0. The two lines are never 1 together.
- R9: In 32-bit mode the word's bits 30:0 are sent LSB first, followed by a parity bit. In 25-bit mode bits 23:0 are sent, followed by a parity bit. The parity bit makes the count of ones in the transmitted word odd.
- R10: After the last bit of every word, both lines are null for exactly 4 bit cells. The next queued word, if `tx_en` is high, starts on the clock edge that ends the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset, asynchronous |
| host_data | input | 16 | Host data bus for word halves and mode word |
| ld_lo_n | input | 1 | Active-low strobe, low half of a word |
| ld_hi_n | input | 1 | Active-low strobe, high half of a word and enqueue |
| cfg_wr_n | input | 1 | Active-low strobe, mode word |
| tx_en | input | 1 | Transmit enable, level sensitive |
| q_empty | output | 1 | High when the queue holds no word |
| line_hi | output | 1 | High-side digital line |
| line_lo | output | 1 | Low-side digital line |

## Verification
The assertions check the following on every cycle:
- The two lines are never active together.
- Both lines are null in the second half of each cell and throughout the gap.
- A word is taken from the queue only while it is non-empty and while `tx_en` is high.
- The queue never accepts a write when full and never exceeds its depth.
- The mode a running word uses never changes mid-word.

Several behaviours can only be shown by the bench's scenarios, which compare every clock against a behavioural model:
- the exact bit order and the parity value;
- the exact gap length between back-to-back words;
- dropping a ninth word;
- finishing a word after `tx_en` falls;
- timing at each of the four rate and length combinations.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_DATA = 2'd1,
        FR_GAP  = 2'd2
    } fr_state_e;

    typedef struct packed {
        logic slow;
        logic short_w;
    } tx_mode_t;

endpackage

// File: rtl/tx_host_port.sv
module tx_host_port
    import a429_tx_pkg::*;
#(
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HW-1:0]   host_data,
    input  logic            ld_lo_n,
    input  logic            ld_hi_n,
    input  logic            cfg_wr_n,
    input  logic            fifo_full,
    output logic            push,
    output logic [2*HW-1:0] push_word,
    output tx_mode_t        mode
);

    typedef struct packed {
        logic          lo_prev;
        logic          hi_prev;
        logic          cfg_prev;
        logic [HW-1:0] lo_half;
        tx_mode_t      mode;
    } port_st_t;

    port_st_t q, d;

    logic lo_fall, hi_fall, cfg_fall;

    always_comb begin
        lo_fall  = q.lo_prev  & ~ld_lo_n;
        hi_fall  = q.hi_prev  & ~ld_hi_n;
        cfg_fall = q.cfg_prev & ~cfg_wr_n;
        d            = q;
        d.lo_prev    = ld_lo_n;
        d.hi_prev    = ld_hi_n;
        d.cfg_prev   = cfg_wr_n;
        if (lo_fall) begin
            d.lo_half = host_data;
        end
        if (cfg_fall) begin
            d.mode.slow    = host_data[0];
            d.mode.short_w = host_data[1];
        end
        // R3: the high-half edge completes the word; R4: dropped when full
        push      = hi_fall & ~fifo_full;
        push_word = {host_data, q.lo_half};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.lo_prev  <= 1'b1;
            q.hi_prev  <= 1'b1;
            q.cfg_prev <= 1'b1;
            q.lo_half  <= '0;
            q.mode     <= '0;
        end else begin
            q <= d;
        end
    end

    assign mode = q.mode;

endmodule

// File: rtl/word_fifo.sv
module word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_word,
    input  logic         pop,
    output logic [W-1:0] head_word,
    output logic         empty,
    output logic         full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t q, d;

    always_comb begin
        d = q;
        if (pop) begin
            d.rd = (q.rd == AW'(DEPTH - 1)) ? '0 : q.rd + 1'b1;
        end
        if (push) begin
            d.mem[q.wr] = push_word;
            d.wr = (q.wr == AW'(DEPTH - 1)) ? '0 : q.wr + 1'b1;
        end
        case ({push, pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign head_word = q.mem[q.rd];
    assign empty     = (q.cnt == '0);
    assign full      = (q.cnt == CW'(DEPTH));

    // R4: the loader never writes into a full queue
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R4: occupancy stays within the depth
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));

    // R5: taking the last word without a new one leaves the queue empty
    p_last_pop_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == CW'(1) && pop && !push) |=> empty);

endmodule

// File: rtl/serial_framer.sv
module serial_framer
    import a429_tx_pkg::*;
#(
    parameter int W         = 32,
    parameter int SHORT_LEN = 25,
    parameter int HALF_FAST = 1000,
    parameter int SLOW_MULT = 8,
    parameter int GAP_BITS  = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_en,
    input  logic         fifo_empty,
    input  logic [W-1:0] head_word,
    input  tx_mode_t     mode,
    output logic         pop,
    output logic         line_hi,
    output logic         line_lo
);

    localparam int HALF_SLOW  = HALF_FAST * SLOW_MULT;
    localparam int CW         = $clog2(HALF_SLOW + 1);
    localparam int GAP_HALVES = 2 * GAP_BITS;
    localparam int BW         = $clog2(W + GAP_HALVES + 1);

    typedef struct packed {
        fr_state_e     state;
        logic [CW-1:0] cnt;
        logic [BW-1:0] idx;
        logic          phase;
        logic [W-1:0]  shreg;
        logic          par;
        logic          slow;
        logic          short_w;
        logic          hi;
        logic          lo;
    } fr_st_t;

    fr_st_t q, d;

    logic [W-1:0]  par_mask;
    logic [CW-1:0] half_lim;
    logic [BW-1:0] last_idx;
    logic [BW-1:0] nidx;
    logic          half_end;
    logic          start_ok;
    logic          nbit;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            par_mask[i] = mode.short_w ? (i < SHORT_LEN - 1) : (i < W - 1);
        end
        half_lim = q.slow ? CW'(HALF_SLOW - 1) : CW'(HALF_FAST - 1);
        last_idx = q.short_w ? BW'(SHORT_LEN - 1) : BW'(W - 1);
        half_end = (q.cnt == half_lim);
        start_ok = tx_en & ~fifo_empty;
        nidx     = q.idx + 1'b1;
        nbit     = (nidx == last_idx) ? q.par : q.shreg[1];
        pop      = 1'b0;
        d        = q;

        case (q.state)
            FR_DATA: begin
                d.cnt = q.cnt + 1'b1;
                if (half_end) begin
                    d.cnt = '0;
                    if (!q.phase) begin
                        d.phase = 1'b1;
                        d.hi    = 1'b0;
                        d.lo    = 1'b0;
                    end else if (q.idx == last_idx) begin
                        d.state = FR_GAP;
                        d.idx   = '0;
                        d.phase = 1'b0;
                    end else begin
                        d.idx   = nidx;
                        d.phase = 1'b0;
                        d.shreg = q.shreg >> 1;
                        d.hi    = nbit;
                        d.lo    = ~nbit;
                    end
                end
            end
            FR_GAP: begin
                d.cnt = q.cnt + 1'b1;
                if (half_end) begin
                    d.cnt = '0;
                    d.idx = nidx;
                    if (q.idx == BW'(GAP_HALVES - 1)) begin
                        d.state = FR_IDLE;
                        d.idx   = '0;
                    end
                end
            end
            default: begin
                d.state = FR_IDLE;
            end
        endcase

        // a new word may start from idle, or on the edge that closes a gap
        if ((q.state == FR_IDLE || (q.state == FR_GAP && half_end &&
             q.idx == BW'(GAP_HALVES - 1))) && start_ok) begin
            pop       = 1'b1;
            d.state   = FR_DATA;
            d.cnt     = '0;
            d.idx     = '0;
            d.phase   = 1'b0;
            d.shreg   = head_word;
            d.par     = ~^(head_word & par_mask);
            d.slow    = mode.slow;
            d.short_w = mode.short_w;
            d.hi      = head_word[0];
            d.lo      = ~head_word[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= FR_IDLE;
        end else begin
            q <= d;
        end
    end

    assign line_hi = q.hi;
    assign line_lo = q.lo;

    // R6: a word is only taken from a non-empty queue
    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !fifo_empty);

    // R6: a word only starts while enabled
    p_pop_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> tx_en);

    // R8: the two lines are never active together
    p_lines_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_hi && line_lo));

    // R8: second half of every cell is null
    p_null_second_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == FR_DATA && q.phase) |-> (!line_hi && !line_lo));

    // R10: the inter-word gap is null on both lines
    p_gap_null_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == FR_GAP) |-> (!line_hi && !line_lo));

    // R2: a running word keeps its mode
    p_mode_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == FR_DATA && !pop && $past(q.state == FR_DATA))
            |-> ($stable(q.slow) && $stable(q.short_w)));

endmodule

// File: rtl/a429_word_tx.sv
module a429_word_tx
    import a429_tx_pkg::*;
#(
    parameter int HW        = 16,
    parameter int DEPTH     = 8,
    parameter int SHORT_LEN = 25,
    parameter int HALF_FAST = 1000,
    parameter int SLOW_MULT = 8,
    parameter int GAP_BITS  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] host_data,
    input  logic          ld_lo_n,
    input  logic          ld_hi_n,
    input  logic          cfg_wr_n,
    input  logic          tx_en,
    output logic          q_empty,
    output logic          line_hi,
    output logic          line_lo
);

    localparam int W = 2 * HW;

    logic         push;
    logic [W-1:0] push_word;
    logic         pop;
    logic [W-1:0] head_word;
    logic         fifo_full;
    tx_mode_t     mode;

    tx_host_port #(.HW(HW)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_data (host_data),
        .ld_lo_n   (ld_lo_n),
        .ld_hi_n   (ld_hi_n),
        .cfg_wr_n  (cfg_wr_n),
        .fifo_full (fifo_full),
        .push      (push),
        .push_word (push_word),
        .mode      (mode)
    );

    word_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_word (push_word),
        .pop       (pop),
        .head_word (head_word),
        .empty     (q_empty),
        .full      (fifo_full)
    );

    serial_framer #(
        .W         (W),
        .SHORT_LEN (SHORT_LEN),
        .HALF_FAST (HALF_FAST),
        .SLOW_MULT (SLOW_MULT),
        .GAP_BITS  (GAP_BITS)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .fifo_empty (q_empty),
        .head_word  (head_word),
        .mode       (mode),
        .pop        (pop),
        .line_hi    (line_hi),
        .line_lo    (line_lo)
    );

endmodule

// File: tb/a429_word_tx_tb.sv
module a429_word_tx_tb;

    localparam int HF    = 4;
    localparam int SM    = 8;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_data = '0;
    logic        ld_lo_n = 1'b1;
    logic        ld_hi_n = 1'b1;
    logic        cfg_wr_n = 1'b1;
    logic        tx_en = 1'b0;
    logic        q_empty;
    logic        line_hi;
    logic        line_lo;

    always #2.5 clk = ~clk;

    a429_word_tx #(.HALF_FAST(HF), .SLOW_MULT(SM)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_data (host_data),
        .ld_lo_n   (ld_lo_n),
        .ld_hi_n   (ld_hi_n),
        .cfg_wr_n  (cfg_wr_n),
        .tx_en     (tx_en),
        .q_empty   (q_empty),
        .line_hi   (line_hi),
        .line_lo   (line_lo)
    );

    int total = 0;
    int bad   = 0;
    string scen = "R1 reset";

    // behavioural model state
    logic [31:0] mq[$];
    logic [1:0]  exp_ln[$];
    string       exp_tag[$];
    logic [15:0] m_lo = '0;
    logic        m_slow = 1'b0, m_short = 1'b0;
    logic        p_lo = 1'b1, p_hi = 1'b1, p_cfg = 1'b1;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", tag, scen, act, expv, $time);
        end
    endtask

    task automatic gen_word(input logic [31:0] w, input logic slow, input logic short_w);
        int h, len;
        logic b, par;
        h   = slow ? HF * SM : HF;
        len = short_w ? 25 : 32;
        par = 1'b1;
        for (int i = 0; i < len; i++) begin
            if (i < len - 1) begin
                b = w[i];
                par = par ^ b;
            end else begin
                b = par;
            end
            for (int c = 0; c < h; c++) begin
                exp_ln.push_back(b ? 2'b10 : 2'b01);
                exp_tag.push_back((i == len - 1) ? "R9 parity" : "R9 data bit");
            end
            for (int c = 0; c < h; c++) begin
                exp_ln.push_back(2'b00);
                exp_tag.push_back("R8 null half");
            end
        end
        for (int c = 0; c < 8 * h; c++) begin
            exp_ln.push_back(2'b00);
            exp_tag.push_back("R10 gap");
        end
    endtask

    // model step, run just after each rising edge with the inputs that edge saw
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst_n) begin
                mq.delete(); exp_ln.delete(); exp_tag.delete();
                m_lo = '0; m_slow = 1'b0; m_short = 1'b0;
                p_lo = 1'b1; p_hi = 1'b1; p_cfg = 1'b1;
                chk({line_hi, line_lo} == 2'b00, "R1 lines", {30'd0, line_hi, line_lo}, 0);
                chk(q_empty == 1'b1, "R1 empty", {31'd0, q_empty}, 1);
            end else begin
                logic full_b;
                logic [1:0] e;
                string t;
                full_b = (mq.size() >= DEPTH);
                if (exp_ln.size() == 0 && tx_en && mq.size() > 0) begin
                    gen_word(mq.pop_front(), m_slow, m_short);
                end
                if (p_hi && !ld_hi_n && !full_b) mq.push_back({host_data, m_lo});
                if (p_lo && !ld_lo_n) m_lo = host_data;
                if (p_cfg && !cfg_wr_n) begin
                    m_slow  = host_data[0];
                    m_short = host_data[1];
                end
                p_lo = ld_lo_n; p_hi = ld_hi_n; p_cfg = cfg_wr_n;
                if (exp_ln.size() > 0) begin
                    e = exp_ln.pop_front();
                    t = exp_tag.pop_front();
                end else begin
                    e = 2'b00;
                    t = "R6 idle";
                end
                chk({line_hi, line_lo} == e, t, {30'd0, line_hi, line_lo}, {30'd0, e});
                chk(q_empty == (mq.size() == 0), "R5 status", {31'd0, q_empty},
                    {31'd0, mq.size() == 0});
            end
        end
    end

    task automatic load_word(input logic [31:0] w);
        @(negedge clk); host_data = w[15:0];  ld_lo_n = 1'b0;
        @(negedge clk); ld_lo_n = 1'b1; host_data = w[31:16]; ld_hi_n = 1'b0;
        @(negedge clk); ld_hi_n = 1'b1;
    endtask

    task automatic set_mode(input logic slow, input logic short_w);
        @(negedge clk); host_data = {14'd0, short_w, slow}; cfg_wr_n = 1'b0;
        @(negedge clk); cfg_wr_n = 1'b1;
    endtask

    task automatic drain();
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (exp_ln.size() == 0 && mq.size() == 0) break;
        end
        repeat (3) @(negedge clk);
        chk(q_empty == 1'b1 && exp_ln.size() == 0, "R5 drained", {31'd0, q_empty}, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog [%s] actual=running expected=finished", scen);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(q_empty == 1'b1, "R1 empty in reset", {31'd0, q_empty}, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({line_hi, line_lo} == 2'b00, "R1 lines after reset", {30'd0, line_hi, line_lo}, 0);

        // R3 / R5 / R6: load with sending disabled
        scen = "R3 R6 load while disabled";
        @(negedge clk); host_data = 16'h5678; ld_lo_n = 1'b0;
        @(negedge clk); ld_lo_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(q_empty == 1'b1, "R3 low half alone", {31'd0, q_empty}, 1);
        @(negedge clk); host_data = 16'h1234; ld_hi_n = 1'b0;
        @(negedge clk); ld_hi_n = 1'b1;
        chk(q_empty == 1'b0, "R5 loaded", {31'd0, q_empty}, 0);
        repeat (60) @(negedge clk);
        chk({line_hi, line_lo} == 2'b00, "R6 held", {30'd0, line_hi, line_lo}, 0);

        scen = "R9 single word";
        tx_en = 1'b1;
        drain();

        scen = "R10 back to back";
        load_word(32'hFFFF_FFFF);
        load_word(32'h0000_0000);
        load_word(32'hA5C3_0F96);
        drain();

        scen = "R4 full queue";
        tx_en = 1'b0;
        for (int k = 0; k < 9; k++) load_word(32'h1111_0000 * (k + 1) + k);
        chk(q_empty == 1'b0, "R4 queue filled", {31'd0, q_empty}, 0);
        tx_en = 1'b1;
        drain();

        scen = "R7 enable drop mid word";
        load_word(32'h8000_0001);
        load_word(32'h7FFF_FFFE);
        repeat (100) @(negedge clk);
        tx_en = 1'b0;
        repeat (400) @(negedge clk);
        chk(q_empty == 1'b0, "R7 second word held", {31'd0, q_empty}, 0);
        chk({line_hi, line_lo} == 2'b00, "R7 idle after finish", {30'd0, line_hi, line_lo}, 0);
        tx_en = 1'b1;
        drain();

        scen = "R2 slow short";
        set_mode(1'b1, 1'b1);
        load_word(32'h00FF_1357);
        load_word(32'hFF00_2468);
        drain();
        scen = "R2 fast short";
        set_mode(1'b0, 1'b1);
        load_word(32'h0081_8181);
        drain();
        scen = "R2 slow long";
        set_mode(1'b1, 1'b0);
        load_word(32'hDEAD_BEEF);
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule